// File: doc/BRIEF.md
# Serial Memory Status and Write-Guard Front End

This block is the command front end of an SPI-slave serial memory with 8K bytes. It receives an SPI mode-0 bit stream framed by an active-low select. It decodes four status-path instructions and keeps the status byte. It drives the serial output through a tri-state buffer. From the status byte and the hardware protect pin it works out whether a write to a given array address, or a write to the status byte, is allowed. The array data paths sit outside the block. The internal programming time is modelled by a busy counter whose length is a parameter.

The select, serial clock and serial input are sampled by the system clock `clk`, which must run at least four times faster than the serial clock. Data is taken on serial-clock rising edges and the output changes on falling edges. The serial link is a plain stream driven by the master and has no back-pressure. The only flow control is the busy flag, which a host reads with the status-read instruction.

The array write path asks for permission through `chk_addr` and `array_wr_ok`. It starts a programming cycle by pulsing `arr_wr_go`.

Top module: `spi_stat_guard`

## Requirements
- R1: After reset, `status_o` is 0x00 and `so_en` is 0. A frame is accepted only after the select has been seen high and then falls.
- R2: The status byte is laid out as bit 7 protect-enable, bits 6..4 reading 0, bits 3..2 block-protect, bit 1 write-enable latch, bit 0 busy.
- R3: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it. Each takes effect on the select rising edge that ends a frame of exactly 8 serial-clock rising edges, whatever the protection state.
- R4: A frame ended with a bit count other than the one its instruction needs (for example 5 or 9) changes no state.
- R5: Opcode 0x05 makes the block drive the status byte, MSB first. The byte is captured when the eighth bit arrives. Each bit is driven from the falling edge after rising edges 8 to 15. At all other times `so_en` is 0. This works while busy.
- R6: Opcode 0x01 followed by one data byte, ending after exactly 16 rising edges, writes data bits 7, 3 and 2 into protect-enable and block-protect. It then sets busy for BUSY_CYCLES clocks and clears the latch when busy ends. This happens only when `status_wr_ok` is 1.
- R7: Hardware protection is active when `wp_n` is 0 and protect-enable is 1. It forces `status_wr_ok` to 0 and leaves `array_wr_ok` free.
- R8: Block-protect 00 protects nothing, 01 protects 0x1800–0x1FFF, 10 protects 0x1000–0x1FFF and 11 protects everything. `array_wr_ok` is 0 for a protected address.
- R9: With the latch at 0, both `array_wr_ok` and `status_wr_ok` are 0.
- R10: An `arr_wr_go` pulse while `array_wr_ok` is 1 starts a busy period that clears the latch at its end. Otherwise the pulse is ignored.
- R11: While busy, both permission outputs are 0, and the write-status, write-enable and write-disable instructions are ignored.
- R12: Any other opcode changes no state and leaves `so_en` at 0 until the select rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Serial select, active low |
| sck | input | 1 | Serial clock, mode 0 |
| mosi | input | 1 | Serial data in |
| so | output | 1 | Serial data out, high-impedance when not driven |
| so_en | output | 1 | High while `so` is driven |
| wp_n | input | 1 | Hardware write-protect pin, active low |
| chk_addr | input | ADDR_W | Array address to test for write permission |
| arr_wr_go | input | 1 | Pulse that starts an array programming cycle |
| array_wr_ok | output | 1 | A write to `chk_addr` is allowed now |
| status_wr_ok | output | 1 | A status write is allowed now |
| status_o | output | 8 | Live status byte |

## Verification
The status byte and busy flag change one clock after the clock edge that samples a rising select or an accepted `arr_wr_go`. Busy then stays high for exactly BUSY_CYCLES clocks. A serial output bit becomes valid one clock after the edge that samples the serial-clock fall. The permission outputs follow `chk_addr` and `wp_n` in the same cycle. The bench model advances on the same rising clock edge as the design. All outputs are compared 1 ns after every falling edge, when inputs and design state have settled. Directed checks read the status byte three clocks after each frame closes, and capture serial bits just before the master's rising edge.

// File: rtl/ssg_pkg.sv
package ssg_pkg;
  localparam int BYTE_BITS = 8;

  typedef enum logic [7:0] {
    OP_WRSR = 8'h01,
    OP_WRDI = 8'h04,
    OP_RDSR = 8'h05,
    OP_WREN = 8'h06
  } op_e;

  typedef struct packed {
    logic       pe;
    logic [2:0] rsvd;
    logic [1:0] bp;
    logic       wel;
    logic       wip;
  } stat_t;
endpackage

// File: rtl/ssg_frame_rx.sv
module ssg_frame_rx
  import ssg_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cs_n,
  input  logic                   sck,
  input  logic                   mosi,
  output logic                   active_o,
  output logic                   sck_fall_o,
  output logic                   op_done_o,
  output logic [BYTE_BITS-1:0]   op_byte_o,
  output logic                   frm_end_o,
  output logic [CNT_W-1:0]       frm_bits_o,
  output logic [2*BYTE_BITS-1:0] frm_word_o
);
  localparam logic [CNT_W-1:0] LAST_OP_BIT = CNT_W'(BYTE_BITS - 1);

  logic                   cs_q, sck_q, armed;
  logic [CNT_W-1:0]       cnt;
  logic [2*BYTE_BITS-1:0] sh;
  logic                   rise;

  assign active_o   = armed & ~cs_n;
  assign rise       = sck & ~sck_q;
  assign sck_fall_o = ~sck & sck_q;
  assign op_done_o  = active_o & rise & (cnt == LAST_OP_BIT);
  assign op_byte_o  = {sh[BYTE_BITS-2:0], mosi};
  assign frm_end_o  = cs_n & ~cs_q & armed;
  assign frm_bits_o = cnt;
  assign frm_word_o = sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q  <= 1'b1;
      sck_q <= 1'b0;
      armed <= 1'b0;
      cnt   <= '0;
      sh    <= '0;
    end else begin
      cs_q  <= cs_n;
      sck_q <= sck;
      if (cs_n) armed <= 1'b1;
      if (!active_o) begin
        cnt <= '0;
      end else if (rise) begin
        sh <= {sh[2*BYTE_BITS-2:0], mosi};
        if (cnt != '1) cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ssg_so_drv.sv
module ssg_so_drv
  import ssg_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 active,
  input  logic                 sck_fall,
  input  logic                 op_done,
  input  logic [BYTE_BITS-1:0] op_byte,
  input  logic [CNT_W-1:0]     cnt,
  input  stat_t                status,
  output logic                 so_en,
  output logic                 so_d
);
  localparam logic [CNT_W-1:0] FIRST_OUT = CNT_W'(BYTE_BITS);
  localparam logic [CNT_W-1:0] LAST_OUT  = CNT_W'(2*BYTE_BITS - 1);

  logic       rd_q;
  logic [7:0] tx_q;
  logic       in_win;

  assign in_win = rd_q && (cnt >= FIRST_OUT) && (cnt <= LAST_OUT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      so_en <= 1'b0;
      so_d  <= 1'b0;
      rd_q  <= 1'b0;
      tx_q  <= '0;
    end else if (!active) begin
      so_en <= 1'b0;
      rd_q  <= 1'b0;
    end else begin
      if (op_done) begin
        rd_q <= (op_byte == OP_RDSR);
        tx_q <= status;
      end
      if (sck_fall) begin
        so_en <= in_win;
        if (in_win) so_d <= tx_q[~cnt[2:0]];
      end
    end
  end
endmodule

// File: rtl/ssg_prot_chk.sv
module ssg_prot_chk #(
  parameter int ADDR_W = 13
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        bp,
  input  logic              pe,
  input  logic              wp_n,
  input  logic              wel,
  input  logic              busy,
  output logic              array_ok,
  output logic              status_ok
);
  localparam logic [ADDR_W-1:0] HALF_LO    = ADDR_W'(2) << (ADDR_W - 2);
  localparam logic [ADDR_W-1:0] QUARTER_LO = ADDR_W'(3) << (ADDR_W - 2);

  logic blk_prot, hw_prot;

  always_comb begin
    unique case (bp)
      2'b00:   blk_prot = 1'b0;
      2'b01:   blk_prot = (addr >= QUARTER_LO);
      2'b10:   blk_prot = (addr >= HALF_LO);
      default: blk_prot = 1'b1;
    endcase
  end

  assign hw_prot   = pe & ~wp_n;
  assign array_ok  = wel & ~busy & ~blk_prot;
  assign status_ok = wel & ~busy & ~hw_prot;
endmodule

// File: rtl/ssg_stat_regs.sv
module ssg_stat_regs
  import ssg_pkg::*;
#(
  parameter int BUSY_CYCLES = 400,
  parameter int CNT_W       = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   frm_end,
  input  logic [CNT_W-1:0]       frm_bits,
  input  logic [2*BYTE_BITS-1:0] frm_word,
  input  logic                   arr_go,
  input  logic                   array_ok,
  input  logic                   status_ok,
  output stat_t                  stat
);
  localparam int BC_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [BC_W-1:0]  BUSY_LOAD = BC_W'(BUSY_CYCLES - 1);
  localparam logic [CNT_W-1:0] ONE_BYTE  = CNT_W'(BYTE_BITS);
  localparam logic [CNT_W-1:0] TWO_BYTE  = CNT_W'(2*BYTE_BITS);

  logic            pe_q, wel_q, busy_q;
  logic [1:0]      bp_q;
  logic [BC_W-1:0] bcnt;
  logic            arr_acc, wrsr_c, wren_c, wrdi_c;

  assign arr_acc = arr_go & array_ok;
  assign wrsr_c  = frm_end & (frm_bits == TWO_BYTE) &
                   (frm_word[2*BYTE_BITS-1:BYTE_BITS] == OP_WRSR) & status_ok & ~arr_acc;
  assign wren_c  = frm_end & (frm_bits == ONE_BYTE) & (frm_word[BYTE_BITS-1:0] == OP_WREN) & ~busy_q;
  assign wrdi_c  = frm_end & (frm_bits == ONE_BYTE) & (frm_word[BYTE_BITS-1:0] == OP_WRDI) & ~busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pe_q   <= 1'b0;
      bp_q   <= 2'b00;
      wel_q  <= 1'b0;
      busy_q <= 1'b0;
      bcnt   <= '0;
    end else begin
      if (busy_q) begin
        if (bcnt == '0) begin
          busy_q <= 1'b0;
          wel_q  <= 1'b0;
        end else begin
          bcnt <= bcnt - 1'b1;
        end
      end else if (arr_acc || wrsr_c) begin
        busy_q <= 1'b1;
        bcnt   <= BUSY_LOAD;
      end
      if (wrsr_c) begin
        pe_q <= frm_word[7];
        bp_q <= frm_word[3:2];
      end
      if (wren_c) wel_q <= 1'b1;
      if (wrdi_c) wel_q <= 1'b0;
    end
  end

  assign stat = '{pe: pe_q, rsvd: 3'b000, bp: bp_q, wel: wel_q, wip: busy_q};
endmodule

// File: rtl/spi_stat_guard.sv
module spi_stat_guard
  import ssg_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int BUSY_CYCLES = 400,
  parameter int CNT_W       = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              mosi,
  output logic              so,
  output logic              so_en,
  input  logic              wp_n,
  input  logic [ADDR_W-1:0] chk_addr,
  input  logic              arr_wr_go,
  output logic              array_wr_ok,
  output logic              status_wr_ok,
  output logic [7:0]        status_o
);
  logic                   active, sck_fall, op_done, frm_end, so_d;
  logic [BYTE_BITS-1:0]   op_byte;
  logic [CNT_W-1:0]       frm_bits;
  logic [2*BYTE_BITS-1:0] frm_word;
  stat_t                  stat;

  ssg_frame_rx #(.CNT_W(CNT_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
    .active_o(active), .sck_fall_o(sck_fall), .op_done_o(op_done),
    .op_byte_o(op_byte), .frm_end_o(frm_end), .frm_bits_o(frm_bits),
    .frm_word_o(frm_word)
  );

  ssg_prot_chk #(.ADDR_W(ADDR_W)) u_prot (
    .addr(chk_addr), .bp(stat.bp), .pe(stat.pe), .wp_n(wp_n),
    .wel(stat.wel), .busy(stat.wip),
    .array_ok(array_wr_ok), .status_ok(status_wr_ok)
  );

  ssg_stat_regs #(.BUSY_CYCLES(BUSY_CYCLES), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .frm_end(frm_end), .frm_bits(frm_bits),
    .frm_word(frm_word), .arr_go(arr_wr_go), .array_ok(array_wr_ok),
    .status_ok(status_wr_ok), .stat(stat)
  );

  ssg_so_drv #(.CNT_W(CNT_W)) u_so (
    .clk(clk), .rst_n(rst_n), .active(active), .sck_fall(sck_fall),
    .op_done(op_done), .op_byte(op_byte), .cnt(frm_bits), .status(stat),
    .so_en(so_en), .so_d(so_d)
  );

  assign so       = so_en ? so_d : 1'bz;
  assign status_o = stat;
endmodule

// File: rtl/ssg_chk.sv
module ssg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       wp_n,
  input logic       so_en,
  input logic [7:0] status_o,
  input logic       array_wr_ok,
  input logic       status_wr_ok
);
  // R5
  so_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !so_en);

  // R9
  latch_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !status_o[1] |-> (!array_wr_ok && !status_wr_ok));

  // R11
  busy_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[0] |-> (!array_wr_ok && !status_wr_ok));

  // R7
  hw_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[7] && !wp_n) |-> !status_wr_ok);

  // R8
  full_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[3:2] == 2'b11) |-> !array_wr_ok);

  // R6
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status_o[0]) |-> !status_o[1]);

  // R10
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_o[0]) |-> $past(status_o[1]));
endmodule

bind spi_stat_guard ssg_chk u_ssg_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wp_n(wp_n), .so_en(so_en),
  .status_o(status_o), .array_wr_ok(array_wr_ok), .status_wr_ok(status_wr_ok)
);

// File: tb/spi_stat_guard_test.sv
`timescale 1ns/1ps
module spi_stat_guard_test;
  localparam int BUSY = 200;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, wp_n = 1'b1, arr_wr_go = 1'b0;
  logic [12:0] chk_addr = '0;
  logic        so, so_en, array_wr_ok, status_wr_ok;
  logic [7:0]  status_o;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0, run_cmp = 1'b0;

  always #2 clk = ~clk;

  spi_stat_guard #(.BUSY_CYCLES(BUSY)) uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
    .so(so), .so_en(so_en), .wp_n(wp_n), .chk_addr(chk_addr),
    .arr_wr_go(arr_wr_go), .array_wr_ok(array_wr_ok),
    .status_wr_ok(status_wr_ok), .status_o(status_o)
  );

  // behavioural reference model
  bit          m_csq, m_sckq, m_armed, m_rd, m_en, m_so, m_wpen, m_wel;
  bit   [1:0]  m_bp;
  bit   [7:0]  m_tx;
  bit   [15:0] m_word;
  int          m_bits, m_left;

  function automatic bit blk(input bit [1:0] bp, input int a);
    case (bp)
      2'd0: return 1'b0;
      2'd1: return a >= 'h1800;
      2'd2: return a >= 'h1000;
      default: return 1'b1;
    endcase
  endfunction

  function automatic bit [7:0] m_stat();
    return {m_wpen, 3'b000, m_bp, m_wel, m_left > 0};
  endfunction

  function automatic bit m_aok();
    return m_wel && m_left == 0 && !blk(m_bp, int'(chk_addr));
  endfunction

  function automatic bit m_sok();
    return m_wel && m_left == 0 && !(m_wpen && !wp_n);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_csq = 1; m_sckq = 0; m_armed = 0; m_rd = 0; m_en = 0; m_so = 0;
      m_wpen = 0; m_wel = 0; m_bp = 0; m_tx = 0; m_word = 0; m_bits = 0; m_left = 0;
    end else begin
      bit act, rise, fall, fend, acc, wr, wren, wrdi, busy_now;
      bit [7:0] st;
      bit [15:0] ow;
      act = m_armed && !cs_n;
      rise = sck && !m_sckq;
      fall = !sck && m_sckq;
      fend = cs_n && !m_csq && m_armed;
      busy_now = m_left > 0;
      st = m_stat();
      ow = m_word;
      acc = arr_wr_go && m_aok();
      wr = fend && m_bits == 16 && ow[15:8] == 8'h01 && m_sok() && !acc;
      wren = fend && m_bits == 8 && ow[7:0] == 8'h06 && !busy_now;
      wrdi = fend && m_bits == 8 && ow[7:0] == 8'h04 && !busy_now;
      if (!act) m_en = 0;
      else if (fall) begin
        if (m_rd && m_bits >= 8 && m_bits <= 15) begin m_en = 1; m_so = m_tx[15 - m_bits]; end
        else m_en = 0;
      end
      if (act && rise) begin
        if (m_bits == 7 && {m_word[6:0], mosi} == 8'h05) begin m_rd = 1; m_tx = st; end
        m_word = {m_word[14:0], mosi};
        if (m_bits < 31) m_bits++;
      end
      if (!act) begin m_bits = 0; m_rd = 0; end
      if (busy_now) begin m_left--; if (m_left == 0) m_wel = 0; end
      else if (acc || wr) m_left = BUSY;
      if (wr) begin m_wpen = ow[7]; m_bp = ow[3:2]; end
      if (wren) m_wel = 1;
      if (wrdi) m_wel = 0;
      if (cs_n) m_armed = 1;
      m_csq = cs_n; m_sckq = sck;
    end
  end

  task automatic cmp(input string rq, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", rq, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (run_cmp && !done) begin
      #1;
      cmp("R2 status byte", status_o, m_stat());
      cmp("R5 so_en", {7'd0, so_en}, {7'd0, m_en});
      if (m_en) cmp("R5 so data", {7'd0, so}, {7'd0, m_so});
      cmp("R8 array_wr_ok", {7'd0, array_wr_ok}, {7'd0, m_aok()});
      cmp("R7 status_wr_ok", {7'd0, status_wr_ok}, {7'd0, m_sok()});
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic xfer(input logic [15:0] w, input int n, output logic [15:0] rx);
    rx = '0;
    cs_n = 1'b0; tick(); tick();
    for (int i = n - 1; i >= 0; i--) begin
      sck = 1'b0; mosi = w[i]; tick(); tick();
      rx = {rx[14:0], so_en ? so : 1'b0};
      sck = 1'b1; tick(); tick();
    end
    sck = 1'b0; tick();
    cs_n = 1'b1; tick(); tick(); tick();
  endtask

  task automatic cmd(input logic [7:0] op);
    logic [15:0] r;
    xfer({8'h00, op}, 8, r);
  endtask

  task automatic wrsr(input logic [7:0] d);
    logic [15:0] r;
    xfer({8'h01, d}, 16, r);
  endtask

  task automatic rdsr(output logic [7:0] v);
    logic [15:0] r;
    xfer({8'h05, 8'h00}, 16, r);
    v = r[7:0];
  endtask

  task automatic idle();
    repeat (BUSY + 10) tick();
  endtask

  task automatic probe(input int a, input string rq, input bit exp);
    chk_addr = a[12:0]; tick();
    cmp(rq, {7'd0, array_wr_ok}, {7'd0, exp});
  endtask

  initial begin
    logic [7:0]  v;
    logic [15:0] r;
    repeat (3) tick();
    rst_n = 1'b1; run_cmp = 1'b1; tick();
    cmp("R1 reset status", status_o, 8'h00);
    cmp("R1 reset so_en", {7'd0, so_en}, 8'h00);

    cmd(8'h06); cmp("R3 enable latch", status_o, 8'h02);
    cmd(8'h04); cmp("R3 disable latch", status_o, 8'h00);
    xfer(16'h0006, 5, r); cmp("R4 five-bit frame", status_o, 8'h00);
    xfer(16'h000D, 9, r); cmp("R4 nine-bit frame", status_o, 8'h00);
    cmd(8'h06);
    cmd(8'h07); cmp("R12 unknown opcode", status_o, 8'h02);
    xfer(16'h0344, 16, r); cmp("R12 unknown two-byte", status_o, 8'h02);
    cmp("R12 no output on unknown", r[7:0], 8'h00);
    rdsr(v); cmp("R5 R2 read status", v, 8'h02);
    probe('h1FFF, "R8 bp00 top", 1'b1);
    cmp("R7 status write allowed", {7'd0, status_wr_ok}, 8'h01);

    wrsr(8'h04); cmp("R6 write starts busy", status_o, 8'h07);
    probe('h0000, "R11 busy blocks array", 1'b0);
    cmd(8'h04); cmp("R11 disable ignored while busy", status_o, 8'h07);
    rdsr(v); cmp("R5 read during busy", v, 8'h07);
    idle(); cmp("R6 latch cleared after busy", status_o, 8'h04);

    cmd(8'h06);
    probe('h17FF, "R8 bp01 below", 1'b1);
    probe('h1800, "R8 bp01 edge", 1'b0);
    wrsr(8'h08); idle(); cmd(8'h06);
    probe('h0FFF, "R8 bp10 below", 1'b1);
    probe('h1000, "R8 bp10 edge", 1'b0);
    wrsr(8'h0C); idle(); cmd(8'h06);
    probe('h0000, "R8 bp11 bottom", 1'b0);
    wrsr(8'h00); idle(); cmp("R6 bp cleared", status_o, 8'h00);
    probe('h0000, "R9 latch low array", 1'b0);
    cmp("R9 latch low status", {7'd0, status_wr_ok}, 8'h00);

    cmd(8'h06); wrsr(8'h80); idle(); cmd(8'h06);
    cmp("R2 protect-enable set", status_o, 8'h82);
    wp_n = 1'b0; tick();
    cmp("R7 hw lock status", {7'd0, status_wr_ok}, 8'h00);
    probe('h1FFF, "R7 hw lock leaves array", 1'b1);
    wrsr(8'h00); cmp("R7 status write refused", status_o, 8'h82);
    wp_n = 1'b1; tick();
    cmp("R7 pin high frees status", {7'd0, status_wr_ok}, 8'h01);

    wrsr(8'h8C); idle(); cmd(8'h06);
    cmp("R10 setup", status_o, 8'h8E);
    chk_addr = 13'h0010; arr_wr_go = 1'b1; tick(); arr_wr_go = 1'b0; tick();
    cmp("R10 protected go ignored", status_o, 8'h8E);
    wrsr(8'h80); idle(); cmd(8'h06);
    chk_addr = 13'h0100; arr_wr_go = 1'b1; tick(); arr_wr_go = 1'b0;
    cmp("R10 go starts busy", status_o, 8'h83);
    idle(); cmp("R10 latch cleared after array write", status_o, 8'h80);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule